// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12). The field is built as a quadratic extension over GF(64). Each operand is cut into a 6-bit upper half and a 6-bit lower half. The halves are combined with four GF(64) products in a Karatsuba-like arrangement, and a fixed constant folds in the extension polynomial. No degree-12 reduction is done.

A second operation, the step, advances a running power of the field's primitive element. It is used when stepping through syndrome or error-locator terms. In step mode the second operand is ignored: a zero input gives 1, and any other input is multiplied by the constant 0xE01.

A parameter selects the output timing. Either the result is registered, with a one-cycle latency and a matching valid flag, or it passes through with no register.

Top module: `gf_tower_unit`

## Requirements
- R1: GF(64) products reduce by x^6+x+1. Operands with zero upper halves give a result whose upper half is 0 and whose lower half is their GF(64) product. For example 0x020 times 0x002 gives 0x003.
- R2: The upper 6 bits of the product (bits 11:6) equal m(ah^al, bh^bl) XOR m(al, bl). Here m is the GF(64) multiply, ah/al are bits 11:6 and 5:0 of operand A, and bh/bl are the same halves of operand B. The product is commutative.
- R3: The lower 6 bits of the product equal m(m(ah, bh), 0x21) XOR m(al, bl). For example 0x040 times 0x040 gives 0x061.
- R4: With op_step = 0, the result is 0 whenever either operand is 0.
- R5: With op_step = 0, an operand B of 0x001 returns operand A unchanged.
- R6: With op_step = 1, an input of 0 gives 0x001, and a nonzero input x gives x times 0xE01 under the R2/R3 product. So an input of 0x001 gives 0xE01.
- R7: With op_step = 1, the value on opnd_b has no effect on the result.
- R8: With PIPELINED = 1, out_valid rises the cycle after each in_valid and falls the cycle after in_valid is low. While in_valid is low, the result holds its last value.
- R9: While rst_n is low, out_valid and result are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_step | input | 1 | 0 = multiply A by B, 1 = primitive-element step of A |
| opnd_a | input | 12 | Operand A |
| opnd_b | input | 12 | Operand B (ignored in step mode) |
| out_valid | output | 1 | Result is fresh |
| result | output | 12 | Product or step result |

## Verification
Operands with an empty upper half exercise only the GF(64) reduction path. Single-bit upper halves isolate the folding constant 0x21 from the cross term. Zero and one operands separate the annihilator and identity cases. Pseudo-random pairs, also applied with their order swapped, compare both halves against a carry-less multiply-then-reduce model. A chain of steps starting from 0 checks the special case, the 0xE01 constant and the fact that opnd_b is ignored. Back-to-back and idle cycles distinguish the latency from the hold behaviour.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
    localparam int unsigned HALF_W = 6;
    localparam int unsigned ELEM_W = 2 * HALF_W;
    // x^6 + x + 1 with the x^6 term kept so a shifted-out bit clears itself
    localparam logic [HALF_W:0]   BASE_POLY  = 7'h43;
    // constant that folds the quadratic extension polynomial into the low half
    localparam logic [HALF_W-1:0] EXT_CONST  = 6'h21;
    // multiplier that advances the primitive-element power by one
    localparam logic [ELEM_W-1:0] STEP_CONST = 12'hE01;

    typedef enum logic {
        OP_MUL  = 1'b0,
        OP_STEP = 1'b1
    } op_e;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
    parameter int unsigned   W    = 6,
    parameter logic [W:0]    POLY = 7'h43
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] z
);
    logic [W-1:0] acc;
    logic [W:0]   sh;

    // shift-and-add over the bits of x, lowest first
    always_comb begin
        acc = '0;
        sh  = {1'b0, y};
        for (int i = 0; i < W; i++) begin
            if (x[i]) begin
                acc = acc ^ sh[W-1:0];
            end
            sh = sh << 1;
            if (sh[W]) begin
                sh = sh ^ POLY;
            end
        end
        z = acc;
    end
endmodule

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul
    import gf_tower_pkg::*;
#(
    parameter int unsigned         HW    = HALF_W,
    parameter logic [HW:0]         POLY  = BASE_POLY,
    parameter logic [HW-1:0]       FOLD  = EXT_CONST
) (
    input  logic [2*HW-1:0] a,
    input  logic [2*HW-1:0] b,
    output logic [2*HW-1:0] p
);
    localparam int unsigned EW = 2 * HW;

    logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
    logic [HW-1:0] prod_cross, prod_low, prod_high, prod_fold;

    assign a_hi = a[EW-1:HW];
    assign a_lo = a[HW-1:0];
    assign b_hi = b[EW-1:HW];
    assign b_lo = b[HW-1:0];

    gf64_mul #(.W(HW), .POLY(POLY)) u_cross (
        .x(a_hi ^ a_lo), .y(b_hi ^ b_lo), .z(prod_cross));
    gf64_mul #(.W(HW), .POLY(POLY)) u_low (
        .x(a_lo), .y(b_lo), .z(prod_low));
    gf64_mul #(.W(HW), .POLY(POLY)) u_high (
        .x(a_hi), .y(b_hi), .z(prod_high));
    gf64_mul #(.W(HW), .POLY(POLY)) u_fold (
        .x(prod_high), .y(FOLD), .z(prod_fold));

    assign p = {prod_cross ^ prod_low, prod_fold ^ prod_low};
endmodule

// File: rtl/gf_tower_unit.sv
module gf_tower_unit
    import gf_tower_pkg::*;
#(
    parameter int unsigned EW        = ELEM_W,
    parameter bit          PIPELINED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          op_step,
    input  logic [EW-1:0] opnd_a,
    input  logic [EW-1:0] opnd_b,
    output logic          out_valid,
    output logic [EW-1:0] result
);
    localparam int unsigned HW = EW / 2;

    op_e           op_sel;
    logic [EW-1:0] mul_b;
    logic [EW-1:0] mul_p;
    logic [EW-1:0] next_res;

    assign op_sel = op_e'(op_step);

    // one shared multiplier: step mode swaps in the fixed constant
    always_comb begin
        unique case (op_sel)
            OP_STEP: mul_b = STEP_CONST[EW-1:0];
            OP_MUL:  mul_b = opnd_b;
            default: mul_b = opnd_b;
        endcase
    end

    gf4096_tower_mul #(.HW(HW)) u_mul (
        .a(opnd_a), .b(mul_b), .p(mul_p));

    always_comb begin
        if (op_sel == OP_STEP && opnd_a == '0) begin
            next_res = {{(EW-1){1'b0}}, 1'b1};
        end else begin
            next_res = mul_p;
        end
    end

    generate
        if (PIPELINED) begin : g_reg
            logic          vld_q;
            logic [EW-1:0] res_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    res_q <= '0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        res_q <= next_res;
                    end
                end
            end
            assign out_valid = vld_q;
            assign result    = res_q;
        end else begin : g_comb
            assign out_valid = in_valid & rst_n;
            assign result    = rst_n ? next_res : '0;
        end
    endgenerate
endmodule

// File: rtl/gf_tower_unit_chk.sv
module gf_tower_unit_chk #(
    parameter int unsigned EW        = 12,
    parameter bit          PIPELINED = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          op_step,
    input logic [EW-1:0] opnd_a,
    input logic [EW-1:0] opnd_b,
    input logic          out_valid,
    input logic [EW-1:0] result
);
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r9: assert (out_valid == 1'b0 && result == '0)
                else $error("R9: outputs not cleared in reset");
        end
    end

    generate
        if (PIPELINED) begin : g_seq
            p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && !op_step && (opnd_a == '0 || opnd_b == '0) |=> result == '0)
                else $error("R4: zero operand gave nonzero product");

            p_identity_r5: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && !op_step && opnd_b == EW'(1) |=> result == $past(opnd_a))
                else $error("R5: multiply by one changed operand");

            p_step_from_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && op_step && opnd_a == '0 |=> result == EW'(1))
                else $error("R6: step of zero is not one");

            p_step_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && op_step |=> result != '0)
                else $error("R6: step produced zero");

            p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid)
                else $error("R8: missing out_valid");

            p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid)
                else $error("R8: spurious out_valid");

            p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(result))
                else $error("R8: result moved while idle");
        end
    endgenerate
endmodule

bind gf_tower_unit gf_tower_unit_chk #(.EW(EW), .PIPELINED(PIPELINED)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_step(op_step),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

// File: tb/sim_gf_tower_unit.sv
`timescale 1ns/1ps
module sim_gf_tower_unit;
    localparam int EW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          op_step = 1'b0;
    logic [EW-1:0] opnd_a = '0;
    logic [EW-1:0] opnd_b = '0;
    logic          out_valid;
    logic [EW-1:0] result;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;
    bit done = 1'b0;

    logic [EW-1:0] exp_q[$];
    string         tag_q[$];
    logic [EW-1:0] last_exp = '0;

    always #2.5 clk = ~clk;

    gf_tower_unit #(.EW(EW), .PIPELINED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_step(op_step),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

    // reference: full carry-less product, then reduce by x^6+x+1
    function automatic logic [5:0] ref_m6(input logic [5:0] x, input logic [5:0] y);
        logic [10:0] pr;
        pr = '0;
        for (int i = 0; i < 6; i++) begin
            if (x[i]) pr = pr ^ (11'(y) << i);
        end
        for (int k = 10; k >= 6; k--) begin
            if (pr[k]) pr = pr ^ (11'h43 << (k - 6));
        end
        return pr[5:0];
    endfunction

    function automatic logic [11:0] ref_mul(input logic [11:0] x, input logic [11:0] y);
        logic [5:0] hi, lo;
        lo = ref_m6(ref_m6(x[11:6], y[11:6]), 6'h21) ^ ref_m6(x[5:0], y[5:0]);
        hi = ref_m6(x[11:6] ^ x[5:0], y[11:6] ^ y[5:0]) ^ ref_m6(x[5:0], y[5:0]);
        return {hi, lo};
    endfunction

    function automatic logic [11:0] ref_step(input logic [11:0] x);
        return (x == 12'h000) ? 12'h001 : ref_mul(x, 12'hE01);
    endfunction

    task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input string req, input logic st, input logic [EW-1:0] a,
                         input logic [EW-1:0] b, input logic [EW-1:0] exp);
        @(negedge clk);
        in_valid = 1'b1;
        op_step  = st;
        opnd_a   = a;
        opnd_b   = b;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        pushed++;
        last_exp = exp;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        opnd_a   = 12'h5A5;
        opnd_b   = 12'h3C3;
    endtask

    // monitor: pops expectations as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8: out_valid with nothing outstanding, actual %h expected none", result);
                end else begin
                    check(tag_q.pop_front(), result, exp_q.pop_front());
                    popped++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [11:0] x;
        repeat (3) @(negedge clk);
        // R9: quiet during reset
        check("R9", {11'd0, out_valid}, 12'h000);
        check("R9", result, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: base-field reduction only
        drive("R1", 1'b0, 12'h020, 12'h002, 12'h003);
        drive("R1", 1'b0, 12'h03F, 12'h01B, ref_mul(12'h03F, 12'h01B));
        // R3/R2: folding constant, cross term
        drive("R3", 1'b0, 12'h040, 12'h040, 12'h061);
        drive("R2", 1'b0, 12'h041, 12'h040, ref_mul(12'h041, 12'h040));
        // R4 zero
        drive("R4", 1'b0, 12'h000, 12'hABC, 12'h000);
        drive("R4", 1'b0, 12'h5A5, 12'h000, 12'h000);
        // R5 identity
        drive("R5", 1'b0, 12'h7C3, 12'h001, 12'h7C3);
        drive("R5", 1'b0, 12'hFFF, 12'h001, 12'hFFF);
        idle();

        // R2/R3 random pairs, swapped for commutativity
        lfsr = 16'hACE1;
        for (int n = 0; n < 24; n++) begin
            logic [11:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[11:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr[15:4];
            drive("R3", 1'b0, a, b, ref_mul(a, b));
            drive("R2", 1'b0, b, a, ref_mul(a, b));
            if (n % 5 == 4) idle();
        end
        idle();

        // R6 step
        drive("R6", 1'b1, 12'h000, 12'h777, 12'h001);
        drive("R6", 1'b1, 12'h001, 12'h000, 12'hE01);
        x = 12'h001;
        for (int n = 0; n < 20; n++) begin
            drive("R6", 1'b1, x, 12'(n * 37), ref_step(x));
            x = ref_step(x);
        end
        // R7: opnd_b ignored in step mode
        drive("R7", 1'b1, 12'h123, 12'h000, ref_step(12'h123));
        drive("R7", 1'b1, 12'h123, 12'hFFF, ref_step(12'h123));
        drive("R7", 1'b1, 12'h800, 12'h001, ref_step(12'h800));

        // R8: hold while idle
        idle();
        @(negedge clk);
        check("R8", {11'd0, out_valid}, 12'h000);
        check("R8", result, last_exp);
        repeat (3) @(negedge clk);
        check("R8", result, last_exp);
        check("R8", 12'(popped), 12'(pushed));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule